// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps an asynchronous DRAM with an internal refresh row counter alive. Once reset is released it sits idle for a fixed power-up pause. It then runs a short burst of CAS-before-RAS cycles on its own to start up the device, and after that it raises a ready flag. From then on an interval timer adds one owed refresh to a small pending counter on each expiry. The memory controller sees a refresh request while anything is owed, and it gives a grant when it can release the bus.

For each cycle it runs, the sequencer takes the strobes through an output multiplexer. The `own` select is high from the first strobe edge until the final precharge cycle, and `done` marks that last cycle. The controller may put off refreshes while it keeps a page open, up to a set limit. At that limit `urgent` tells it that it must grant. Write enable stays high at all times and the address bus is not driven. All times are parameters counted in clock cycles. The defaults suit a 60 ns grade part clocked at 200 MHz: a 200 µs pause, 8 start-up cycles, and one refresh every 15.6 µs, which gives 512 rows in 8 ms.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and directly after reset, `ready`, `req`, `urgent`, `own` and `done` are 0 and `ras_n`, `cas_n`, `we_n` are 1.
- R2: `own` stays 0 for the first PAUSE_CYC clocks after reset is released. The first start-up cycle has `own` high on clock PAUSE_CYC+2.
- R3: After the pause, exactly INIT_CNT cycles run without any grant. `ready` is 0 in the `done` cycle of the last one and 1 on the next clock. No further cycle starts until a grant arrives.
- R4: Every cycle holds `own` high for CSR_CYC+RAS_CYC+PRE_CYC clocks. Let i count the clocks from 0. `cas_n` is 0 while i < CSR_CYC+CHR_CYC. `ras_n` is 0 while CSR_CYC <= i < CSR_CYC+RAS_CYC. `done` is 1 only at the final i.
- R5: `we_n` is 1 in every cycle.
- R6: Once `ready` is 1, one refresh becomes owed every INTERVAL_CYC clocks. The first one shows as `req` exactly INTERVAL_CYC clocks after `ready` rises.
- R7: No refresh cycle starts without `grant`, however long `req` has been high. If `grant` is seen with `req` high while idle, `own` rises two clocks later.
- R8: The owed count rises on each interval and falls on each completed refresh. `req` is high while it is non-zero, and `urgent` is high while it equals MAX_PEND.
- R9: Intervals that expire while MAX_PEND are owed are dropped. Holding `grant` then runs exactly MAX_PEND cycles before `req` falls.
- R10: While `own` is 0, `ras_n` and `cas_n` are both 1.
- R11: Once `ready` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Controller allows a refresh cycle to start |
| ready | output | 1 | Start-up finished, memory usable |
| req | output | 1 | At least one refresh owed |
| urgent | output | 1 | Owed count at its limit, grant required |
| own | output | 1 | Sequencer drives the strobes (mux select) |
| done | output | 1 | Final clock of a refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench keeps the strobe timing at its default values: a 1-clock CAS lead, a 3-clock CAS hold, 12 clocks of RAS low and 9 clocks of precharge. With these settings every clock of every cycle is compared against the waveform the bench derives itself. The pause is cut to 20 clocks and start-up to 3 cycles, the interval is 200 clocks and the owed limit is 3. These values let the bench walk through the whole pause, every start-up cycle, filling and overfilling the owed counter, and draining it, all within a few thousand clocks. The long interval also keeps a timer tick from landing inside the drain burst, so the number of drained cycles is exact.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // length of one refresh cycle in clocks
  function automatic int unsigned cyc_len(int unsigned csr, int unsigned ras,
                                          int unsigned pre);
    return csr + ras + pre;
  endfunction

  // column strobe low: from cycle start through the hold after row fall
  function automatic logic col_low(int unsigned i, int unsigned csr,
                                   int unsigned chr);
    return i < (csr + chr);
  endfunction

  // row strobe low: after the column lead, for the row pulse width
  function automatic logic row_low(int unsigned i, int unsigned csr,
                                   int unsigned ras);
    return (i >= csr) && (i < (csr + ras));
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dseq_pend.sv
module dseq_pend #(
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic any,
  output logic full
);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] cnt;

  assign any  = (cnt != '0);
  assign full = (cnt == PW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (!full) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      if (any) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dseq_cbr.sv
module dseq_cbr
  import dseq_pkg::*;
#(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned CHR_CYC = 3,
  parameter int unsigned RAS_CYC = 12,
  parameter int unsigned PRE_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last,
  output logic own,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned TOTAL = cyc_len(CSR_CYC, RAS_CYC, PRE_CYC);
  localparam int unsigned PW    = $clog2(TOTAL + 1);

  logic [PW-1:0] ph;

  assign last = busy && (ph == PW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ph   <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
      ph   <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // registered strobes: one clock behind the phase counter, glitch free
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own   <= 1'b0;
      done  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      own   <= busy;
      done  <= last;
      ras_n <= !(busy && row_low(int'(ph), CSR_CYC, RAS_CYC));
      cas_n <= !(busy && col_low(int'(ph), CSR_CYC, CHR_CYC));
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dseq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 40000,
  parameter int unsigned INIT_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 3120,
  parameter int unsigned MAX_PEND     = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 3,
  parameter int unsigned RAS_CYC      = 12,
  parameter int unsigned PRE_CYC      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic ready,
  output logic req,
  output logic urgent,
  output logic own,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned IW = $clog2(INIT_CNT + 1);

  phase_e        phase;
  logic [IW-1:0] init_starts;
  logic          pause_tick, ival_tick;
  logic          busy, last;
  logic          pend_any, pend_full;
  logic          go_init, go_ref, start;
  logic          init_fin;

  assign go_init  = (phase == PH_INIT) && !busy && (init_starts != IW'(INIT_CNT));
  assign go_ref   = (phase == PH_RUN) && !busy && pend_any && grant;
  assign start    = go_init || go_ref;
  assign init_fin = (phase == PH_INIT) && (init_starts == IW'(INIT_CNT)) && done;

  dseq_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_tick)
  );

  dseq_timer #(.LIMIT(INTERVAL_CYC)) u_ival (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(ival_tick)
  );

  dseq_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .inc(ival_tick), .dec(last && (phase == PH_RUN)),
    .any(pend_any), .full(pend_full)
  );

  dseq_cbr #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
  ) u_cbr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .last(last), .own(own), .done(done),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_PAUSE;
      init_starts <= '0;
    end else begin
      if (go_init) init_starts <= init_starts + 1'b1;
      case (phase)
        PH_PAUSE: if (pause_tick) phase <= PH_INIT;
        PH_INIT:  if (init_fin)   phase <= PH_RUN;
        default:  phase <= PH_RUN;
      endcase
    end
  end

  assign ready  = (phase == PH_RUN);
  assign req    = pend_any;
  assign urgent = pend_full;
  assign we_n   = 1'b1;
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic ready,
  input logic req,
  input logic urgent,
  input logic own,
  input logic done,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  // R10
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own |-> (ras_n && cas_n));

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4
  done_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> own);

  // R4
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own) |-> $past(done));

  // R5
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_n);

  // R11
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R8
  urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);

  // R6
  no_req_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !req);

  // R7
  refresh_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(own) && ready) |-> $past(grant, 2));
endmodule

bind dram_refresh_seq dseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .ready(ready), .req(req),
  .urgent(urgent), .own(own), .done(done), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int P    = 20;
  localparam int N    = 3;
  localparam int IV   = 200;
  localparam int M    = 3;
  localparam int CSR  = 1;
  localparam int CHR  = 3;
  localparam int RASW = 12;
  localparam int PRE  = 9;
  localparam int T    = CSR + RASW + PRE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic ready, req, urgent, own, done, ras_n, cas_n, we_n;

  int checks = 0;
  int fails = 0;
  int mon_bad = 0;
  int rdy_at_done, rdy_after;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .INIT_CNT(N), .INTERVAL_CYC(IV), .MAX_PEND(M),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW), .PRE_CYC(PRE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant), .ready(ready), .req(req),
    .urgent(urgent), .own(own), .done(done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // continuous port monitor, R5 / R10 / R11
  logic rdy_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (we_n !== 1'b1) mon_bad++;
      if (!own && (ras_n !== 1'b1 || cas_n !== 1'b1)) mon_bad++;
      if (rdy_seen && !ready) mon_bad++;
      if (ready) rdy_seen = 1'b1;
    end
  end

  // called on the negedge where own first reads 1; leaves on the negedge after
  task automatic shape(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < T; i++) begin
      if (own !== 1'b1) bad++;
      if (cas_n !== !(i < CSR + CHR)) bad++;
      if (ras_n !== !(i >= CSR && i < CSR + RASW)) bad++;
      if (done !== (i == T - 1)) bad++;
      if (i == T - 1) rdy_at_done = ready;
      @(negedge clk);
    end
    rdy_after = ready;
    if (own !== 1'b0) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic wait_own(output int waited);
    waited = 0;
    while (own !== 1'b1 && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    int n, w, t, cnt, early;
    // R1 during reset
    repeat (4) @(negedge clk);
    check(ready == 0 && req == 0 && urgent == 0 && own == 0 && done == 0 &&
          ras_n == 1 && cas_n == 1 && we_n == 1, "R1 reset state", ready, 0);
    rst_n = 1'b1;
    // R2 pause
    n = 0; early = 0;
    do begin
      @(negedge clk);
      n++;
      if (n <= P && own) early++;
    end while (own !== 1'b1 && n < P + 50);
    check(early == 0, "R2 quiet pause", early, 0);
    check(n == P + 2, "R2 first cycle clock", n, P + 2);
    // R3 / R4 start-up burst
    for (int k = 0; k < N; k++) begin
      if (k > 0) wait_own(w);
      shape("R4 init cycle shape");
      if (k < N - 1) check(rdy_after == 0, "R3 ready held low", rdy_after, 0);
    end
    check(rdy_at_done == 0, "R3 ready low at last done", rdy_at_done, 0);
    check(rdy_after == 1, "R3 ready after last done", rdy_after, 1);
    // ready visible now: t = 0
    t = 0; early = 0;
    while (t < 5 * IV) begin
      @(negedge clk);
      t++;
      if (own) early++;
      if (t == IV - 1) check(req == 0, "R6 req before interval", req, 0);
      if (t == IV) check(req == 1, "R6 req at interval", req, 1);
      if (t == 2 * IV) check(urgent == 0, "R8 not urgent at 2", urgent, 0);
      if (t == 3 * IV) check(urgent == 1, "R8 urgent at limit", urgent, 1);
    end
    check(early == 0, "R3 R7 no cycle without grant", early, 0);
    check(urgent == 1 && req == 1, "R9 saturated still urgent", urgent, 1);
    // R7 grant latency
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    check(own == 0, "R7 own not yet", own, 0);
    @(negedge clk);
    check(own == 1, "R7 own two clocks after grant", own, 1);
    shape("R4 refresh cycle shape");
    check(urgent == 0 && req == 1, "R8 count drops after refresh", urgent, 0);
    cnt = 1;
    while (req && cnt < 10) begin
      wait_own(w);
      shape("R4 drain cycle shape");
      cnt++;
    end
    grant = 1'b0;
    check(cnt == M, "R9 drained cycles", cnt, M);
    check(req == 0 && urgent == 0, "R8 nothing owed", req, 0);
    // next tick resumes from empty
    repeat (IV) @(negedge clk);
    check(req == 1 && urgent == 0, "R8 one owed after next tick", urgent, 0);
    check(mon_bad == 0, "R5 R10 R11 port monitor", mon_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule